// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This unit keeps two independent 16-bit data pointers for an 8051-style processor core. Software reaches each pointer as two byte-wide special-function registers, one for the low byte and one for the high byte. The second pointer's registers sit at addresses that the first pointer does not use. A one-bit select register chooses which pointer is active. The instruction decoder drives three single-cycle strobes: increment, decrement and 16-bit load. Each strobe acts only on the active pointer. The active pointer's value is driven on `ptrAddr` for use as a data memory address.

The byte register interface is synchronous for writes. Reads are combinational from `sfrAddr`. Register addresses are parameters. Their defaults are low byte 0x82 and high byte 0x83 for pointer 0, low byte 0x84 and high byte 0x85 for pointer 1, and the select register at 0x86.

Top module: `dual_dptr_unit`

## Requirements
- R1: After reset both pointers are 0x0000 and the select bit is 0, so `ptrAddr` reads 0x0000 and every mapped register reads 0x00.
- R2: A write to a pointer's low-byte address (0x82 for pointer 0, 0x84 for pointer 1) or high-byte address (0x83 / 0x85) updates only that byte, leaves the other byte unchanged, and reads back the next cycle.
- R3: Bit 0 of the select register at 0x86 chooses the active pointer (0 = pointer 0, 1 = pointer 1). Bits 7..1 read as 0. `ptrAddr` shows the active pointer from the cycle after the write.
- R4: An increment strobe adds one to the active pointer, wrapping from 0xFFFF to 0x0000. The inactive pointer is unchanged.
- R5: A decrement strobe subtracts one from the active pointer, wrapping from 0x0000 to 0xFFFF. The inactive pointer is unchanged.
- R6: A load strobe writes `loadValue` into the active pointer only. The inactive pointer keeps its value.
- R7: When several strobes are asserted together, load takes precedence over increment, and increment takes precedence over decrement.
- R8: If a byte write targets the active pointer in the same cycle as a strobe, the byte write is applied and the strobe is discarded. If the byte write targets the inactive pointer, both the write and the strobe take effect.
- R9: A select-register write in the same cycle as a strobe applies the strobe to the previously selected pointer.
- R10: A write to an unmapped address changes nothing, and a read of an unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sfrWrEn | input | 1 | Register byte write enable |
| sfrAddr | input | 8 | Register address for reads and writes |
| sfrWrData | input | 8 | Register write byte |
| sfrRdData | output | 8 | Register read byte (combinational) |
| incStrobe | input | 1 | Increment active pointer |
| decStrobe | input | 1 | Decrement active pointer |
| loadStrobe | input | 1 | Load active pointer with `loadValue` |
| loadValue | input | 16 | Value for a load |
| ptrAddr | output | 16 | Active pointer value |

## Verification
A software byte write and a decoder strobe can land in the same cycle. The bench provokes this with three collisions, each in a single cycle:
- a low-byte write to the active pointer together with an increment;
- a high-byte write together with a load;
- a write to the inactive pointer's byte together with an increment.

The bench then judges both pointers through register reads and `ptrAddr`. It expects the strobe to be dropped only when the write hits the active pointer. A select write together with an increment is also driven, to check that the old pointer advances and the new one is presented afterwards.

// File: rtl/dptr_pkg.sv
`timescale 1ns/1ps
package dptr_pkg;
  localparam int NUM_PTR = 2;
  localparam int BYTE_W  = 8;
  localparam int PTR_W   = 2 * BYTE_W;
  localparam int SEL_W   = $clog2(NUM_PTR);

  typedef enum logic [1:0] {OP_NONE, OP_INC, OP_DEC, OP_LOAD} ptrOp_e;

  typedef struct packed {
    logic [NUM_PTR-1:0] wrLo;
    logic [NUM_PTR-1:0] wrHi;
    logic [NUM_PTR-1:0] opEn;
    ptrOp_e             op;
  } ptrCmd_t;
endpackage

// File: rtl/dptr_ctrl.sv
`timescale 1ns/1ps
module dptr_ctrl
  import dptr_pkg::*;
#(
  parameter logic [7:0] ADDR_LO0 = 8'h82,
  parameter logic [7:0] ADDR_HI0 = 8'h83,
  parameter logic [7:0] ADDR_LO1 = 8'h84,
  parameter logic [7:0] ADDR_HI1 = 8'h85,
  parameter logic [7:0] ADDR_SEL = 8'h86
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            sfrWrEn,
  input  logic [7:0]                      sfrAddr,
  input  logic                            selData,
  input  logic                            incStrobe,
  input  logic                            decStrobe,
  input  logic                            loadStrobe,
  input  logic [NUM_PTR-1:0][PTR_W-1:0]   ptrVal,
  output ptrCmd_t                         cmd,
  output logic [SEL_W-1:0]                activeSel,
  output logic [BYTE_W-1:0]               sfrRdData
);
  localparam logic [NUM_PTR-1:0][7:0] LO_ADDRS = {ADDR_LO1, ADDR_LO0};
  localparam logic [NUM_PTR-1:0][7:0] HI_ADDRS = {ADDR_HI1, ADDR_HI0};

  logic [SEL_W-1:0] selReg;
  ptrOp_e           opNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selReg <= '0;
    else if (sfrWrEn && sfrAddr == ADDR_SEL) selReg <= SEL_W'(selData);
  end
  assign activeSel = selReg;

  always_comb begin
    if (loadStrobe)     opNext = OP_LOAD;
    else if (incStrobe) opNext = OP_INC;
    else if (decStrobe) opNext = OP_DEC;
    else                opNext = OP_NONE;
  end

  always_comb begin
    cmd.op = opNext;
    for (int i = 0; i < NUM_PTR; i++) begin
      cmd.wrLo[i] = sfrWrEn && (sfrAddr == LO_ADDRS[i]);
      cmd.wrHi[i] = sfrWrEn && (sfrAddr == HI_ADDRS[i]);
      cmd.opEn[i] = (opNext != OP_NONE) && (selReg == SEL_W'(i))
                    && !(cmd.wrLo[i] || cmd.wrHi[i]);
    end
  end

  always_comb begin
    sfrRdData = '0;
    if (sfrAddr == ADDR_SEL) sfrRdData = BYTE_W'(selReg);
    for (int i = 0; i < NUM_PTR; i++) begin
      if (sfrAddr == LO_ADDRS[i]) sfrRdData = ptrVal[i][BYTE_W-1:0];
      if (sfrAddr == HI_ADDRS[i]) sfrRdData = ptrVal[i][PTR_W-1:BYTE_W];
    end
  end
endmodule

// File: rtl/dptr_datapath.sv
`timescale 1ns/1ps
module dptr_datapath
  import dptr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  ptrCmd_t                       cmd,
  input  logic [BYTE_W-1:0]             wrByte,
  input  logic [PTR_W-1:0]              loadValue,
  input  logic [SEL_W-1:0]              activeSel,
  output logic [NUM_PTR-1:0][PTR_W-1:0] ptrVal,
  output logic [PTR_W-1:0]              ptrAddr
);
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic [PTR_W-1:0] ptrQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptrQ <= '0;
      end else if (cmd.wrLo[g] || cmd.wrHi[g]) begin
        if (cmd.wrLo[g]) ptrQ[BYTE_W-1:0]     <= wrByte;
        if (cmd.wrHi[g]) ptrQ[PTR_W-1:BYTE_W] <= wrByte;
      end else if (cmd.opEn[g]) begin
        unique case (cmd.op)
          OP_INC:  ptrQ <= ptrQ + PTR_W'(1);
          OP_DEC:  ptrQ <= ptrQ - PTR_W'(1);
          OP_LOAD: ptrQ <= loadValue;
          default: ptrQ <= ptrQ;
        endcase
      end
    end
    assign ptrVal[g] = ptrQ;
  end

  assign ptrAddr = ptrVal[activeSel];
endmodule

// File: rtl/dual_dptr_unit.sv
`timescale 1ns/1ps
module dual_dptr_unit
  import dptr_pkg::*;
#(
  parameter logic [7:0] ADDR_LO0 = 8'h82,
  parameter logic [7:0] ADDR_HI0 = 8'h83,
  parameter logic [7:0] ADDR_LO1 = 8'h84,
  parameter logic [7:0] ADDR_HI1 = 8'h85,
  parameter logic [7:0] ADDR_SEL = 8'h86
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sfrWrEn,
  input  logic [7:0]  sfrAddr,
  input  logic [7:0]  sfrWrData,
  output logic [7:0]  sfrRdData,
  input  logic        incStrobe,
  input  logic        decStrobe,
  input  logic        loadStrobe,
  input  logic [15:0] loadValue,
  output logic [15:0] ptrAddr
);
  ptrCmd_t                       cmd;
  logic [SEL_W-1:0]              activeSel;
  logic [NUM_PTR-1:0][PTR_W-1:0] ptrVal;

  dptr_ctrl #(
    .ADDR_LO0(ADDR_LO0), .ADDR_HI0(ADDR_HI0),
    .ADDR_LO1(ADDR_LO1), .ADDR_HI1(ADDR_HI1),
    .ADDR_SEL(ADDR_SEL)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .sfrWrEn(sfrWrEn), .sfrAddr(sfrAddr),
    .selData(sfrWrData[0]), .incStrobe(incStrobe), .decStrobe(decStrobe),
    .loadStrobe(loadStrobe), .ptrVal(ptrVal), .cmd(cmd),
    .activeSel(activeSel), .sfrRdData(sfrRdData)
  );

  dptr_datapath i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrByte(sfrWrData),
    .loadValue(loadValue), .activeSel(activeSel), .ptrVal(ptrVal),
    .ptrAddr(ptrAddr)
  );
endmodule

// File: rtl/dptr_checker.sv
`timescale 1ns/1ps
module dptr_checker #(
  parameter logic [7:0] ADDR_SEL = 8'h86
) (
  input logic        clk,
  input logic        rstN,
  input logic        sfrWrEn,
  input logic [7:0]  sfrAddr,
  input logic        selData,
  input logic        incStrobe,
  input logic        decStrobe,
  input logic        loadStrobe,
  input logic [15:0] loadValue,
  input logic [15:0] ptrAddr,
  input logic        activeSel
);
  p_inc_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!sfrWrEn && incStrobe && !loadStrobe) |=> ptrAddr == $past(ptrAddr) + 16'd1);

  p_dec_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!sfrWrEn && decStrobe && !incStrobe && !loadStrobe)
      |=> ptrAddr == $past(ptrAddr) - 16'd1);

  p_load_active_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!sfrWrEn && loadStrobe) |=> ptrAddr == $past(loadValue));

  p_select_bit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sfrWrEn && sfrAddr == ADDR_SEL) |=> activeSel == $past(selData));

  p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!sfrWrEn && !incStrobe && !decStrobe && !loadStrobe) |=> $stable(ptrAddr));
endmodule

bind dual_dptr_unit dptr_checker #(.ADDR_SEL(ADDR_SEL)) i_dptr_checker (
  .clk(clk), .rstN(rstN), .sfrWrEn(sfrWrEn), .sfrAddr(sfrAddr),
  .selData(sfrWrData[0]), .incStrobe(incStrobe), .decStrobe(decStrobe),
  .loadStrobe(loadStrobe), .loadValue(loadValue), .ptrAddr(ptrAddr),
  .activeSel(activeSel)
);

// File: tb/test_dual_dptr_unit.sv
`timescale 1ns/1ps
module test_dual_dptr_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sfrWrEn = 1'b0;
  logic [7:0]  sfrAddr = 8'h00;
  logic [7:0]  sfrWrData = 8'h00;
  logic [7:0]  sfrRdData;
  logic        incStrobe = 1'b0;
  logic        decStrobe = 1'b0;
  logic        loadStrobe = 1'b0;
  logic [15:0] loadValue = 16'h0000;
  logic [15:0] ptrAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_dptr_unit i_dual_dptr_unit (
    .clk(clk), .rstN(rstN), .sfrWrEn(sfrWrEn), .sfrAddr(sfrAddr),
    .sfrWrData(sfrWrData), .sfrRdData(sfrRdData), .incStrobe(incStrobe),
    .decStrobe(decStrobe), .loadStrobe(loadStrobe), .loadValue(loadValue),
    .ptrAddr(ptrAddr)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock with the given write and strobes, sample after the edge
  task automatic cycle(input logic wr, input logic [7:0] a, input logic [7:0] d,
                       input logic inc, input logic dec, input logic ld,
                       input logic [15:0] lv);
    @(negedge clk);
    sfrWrEn = wr; sfrAddr = a; sfrWrData = d;
    incStrobe = inc; decStrobe = dec; loadStrobe = ld; loadValue = lv;
    @(posedge clk); #1;
    sfrWrEn = 1'b0; incStrobe = 1'b0; decStrobe = 1'b0; loadStrobe = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cycle(1'b1, a, d, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    sfrAddr = a; #1;
    check(req, {8'h00, sfrRdData}, {8'h00, exp});
  endtask

  task automatic t_reset;
    #1;
    check("R1 ptrAddr", ptrAddr, 16'h0000);
    for (int a = 8'h82; a <= 8'h86; a++) rd("R1 reg", 8'(a), 8'h00);
  endtask

  task automatic t_bytes;
    wr(8'h82, 8'h34); wr(8'h83, 8'h12);
    rd("R2 p0 lo", 8'h82, 8'h34); rd("R2 p0 hi", 8'h83, 8'h12);
    check("R2 ptrAddr", ptrAddr, 16'h1234);
    wr(8'h84, 8'hCD);
    rd("R2 p1 hi untouched", 8'h85, 8'h00); rd("R2 p1 lo", 8'h84, 8'hCD);
    wr(8'h85, 8'hAB);
    rd("R2 p1 hi", 8'h85, 8'hAB);
    wr(8'h82, 8'h55);
    rd("R2 p0 hi kept", 8'h83, 8'h12);
    check("R2 ptrAddr p0", ptrAddr, 16'h1255);
  endtask

  task automatic t_select;
    wr(8'h86, 8'hFF);
    rd("R3 sel reads 1", 8'h86, 8'h01);
    check("R3 ptrAddr p1", ptrAddr, 16'hABCD);
    wr(8'h86, 8'hFE);
    rd("R3 sel reads 0", 8'h86, 8'h00);
    check("R3 ptrAddr p0", ptrAddr, 16'h1255);
  endtask

  task automatic t_inc;
    cycle(1'b0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b1, 16'hFFFE);
    cycle(1'b0, 8'h0, 8'h0, 1'b1, 1'b0, 1'b0, 16'h0);
    check("R4 inc", ptrAddr, 16'hFFFF);
    cycle(1'b0, 8'h0, 8'h0, 1'b1, 1'b0, 1'b0, 16'h0);
    check("R4 inc wrap", ptrAddr, 16'h0000);
    rd("R4 p1 lo kept", 8'h84, 8'hCD); rd("R4 p1 hi kept", 8'h85, 8'hAB);
  endtask

  task automatic t_dec;
    cycle(1'b0, 8'h0, 8'h0, 1'b0, 1'b1, 1'b0, 16'h0);
    check("R5 dec wrap", ptrAddr, 16'hFFFF);
    wr(8'h86, 8'h01);
    cycle(1'b0, 8'h0, 8'h0, 1'b0, 1'b1, 1'b0, 16'h0);
    check("R5 dec p1", ptrAddr, 16'hABCC);
    rd("R5 p0 lo kept", 8'h82, 8'hFF); rd("R5 p0 hi kept", 8'h83, 8'hFF);
  endtask

  task automatic t_load;
    cycle(1'b0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b1, 16'h0F0F);
    check("R6 load p1", ptrAddr, 16'h0F0F);
    rd("R6 p0 lo kept", 8'h82, 8'hFF); rd("R6 p0 hi kept", 8'h83, 8'hFF);
    wr(8'h86, 8'h00);
  endtask

  task automatic t_prio;
    cycle(1'b0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b1, 16'h1000);
    cycle(1'b0, 8'h0, 8'h0, 1'b1, 1'b1, 1'b0, 16'h0);
    check("R7 inc over dec", ptrAddr, 16'h1001);
    cycle(1'b0, 8'h0, 8'h0, 1'b1, 1'b1, 1'b1, 16'h2222);
    check("R7 load over inc", ptrAddr, 16'h2222);
  endtask

  task automatic t_conflict;
    cycle(1'b1, 8'h82, 8'h77, 1'b1, 1'b0, 1'b0, 16'h0);
    check("R8 write wins over inc", ptrAddr, 16'h2277);
    cycle(1'b1, 8'h83, 8'h99, 1'b0, 1'b0, 1'b1, 16'h5555);
    check("R8 write wins over load", ptrAddr, 16'h9977);
    cycle(1'b1, 8'h84, 8'h11, 1'b1, 1'b0, 1'b0, 16'h0);
    check("R8 inactive write with inc", ptrAddr, 16'h9978);
    rd("R8 p1 lo written", 8'h84, 8'h11);
  endtask

  task automatic t_selop;
    cycle(1'b1, 8'h86, 8'h01, 1'b1, 1'b0, 1'b0, 16'h0);
    check("R9 new pointer shown", ptrAddr, 16'h0F11);
    rd("R9 old pointer advanced", 8'h82, 8'h79);
  endtask

  task automatic t_unmapped;
    wr(8'h90, 8'hAA);
    rd("R10 unmapped read", 8'h90, 8'h00);
    check("R10 ptrAddr kept", ptrAddr, 16'h0F11);
    rd("R10 p0 lo kept", 8'h82, 8'h79); rd("R10 p0 hi kept", 8'h83, 8'h99);
    rd("R10 sel kept", 8'h86, 8'h01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rstN = 1'b1;
    t_bytes();
    t_select();
    t_inc();
    t_dec();
    t_load();
    t_prio();
    t_conflict();
    t_selop();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule